// File: doc/BRIEF.md
# Pruned Bit-Reversal Address Generator

This block produces the read or write address sequence for a variable-length interleaver. The caller supplies a codeword length L and a start strobe. The block picks the smallest power-of-two frame size M = 2^n that still holds L. It then walks a mother index from 0 upward. Each index is turned into an address by mirroring its n low bits. Mirrored values of L or more are dropped, so the output is a complete, gap-free permutation of 0..L-1.

Every mirrored index that is dropped shifts all later output positions, so the sequence is built serially. A plain serial loop would lose a cycle on each dropped index. Instead, the block examines several consecutive mother indices in each cycle and emits the first one that is in range. When n is minimal, two neighbouring indices of the form 2k and 2k+1 can never both be dropped. With two or more lanes, the block therefore delivers one address per cycle for as long as the consumer accepts them.

Addresses leave through a valid/ready pair. A one-cycle done pulse follows the last accepted address. After that pulse the block waits for the next start.

Top module: `pbr_addr_gen`

## Requirements
- R1: While reset is asserted, and on the first cycle after its release, valid_o and done_o are both low.
- R2: For an accepted length L, the accepted addresses are exactly the n-bit mirror images of mother indices 0, 1, 2, ... in increasing index order, keeping only images below L. Bit b of the index becomes bit n-1-b of the address.
- R3: n is the smallest integer with L <= 2^n. L = 1 gives n = 0 and a single address 0. A power-of-two L gives the plain n-bit reversal of all indices.
- R4: Every address presented with valid_o high is below L, and no address value repeats within one run.
- R5: With ready_i held high, valid_o stays high on every cycle from the first address to the L-th address, with no empty cycle between them.
- R6: While valid_o is high and ready_i is low, valid_o stays high and addr_o keeps its value on the following cycle.
- R7: done_o is high for exactly one cycle, on the cycle after the handshake of the L-th address. valid_o is low on that cycle and stays low until a new start.
- R8: A start is taken only while the block is idle and only for 1 <= len_i <= 2^NMAX. A start during a run, or with len_i = 0, or with len_i above 2^NMAX, has no effect: no address and no done pulse appear, and a run in progress continues unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Begin a run with the length on len_i |
| len_i | input | NMAX+1 | Codeword length L, sampled with start_i |
| ready_i | input | 1 | Consumer accepts addr_o this cycle |
| valid_o | output | 1 | addr_o holds a valid address |
| addr_o | output | NMAX | Interleaved address |
| done_o | output | 1 | One-cycle pulse after the last handshake of a run |

## Verification
The hardest case to reach from the ports is a stall that falls right on a mother index whose mirror image is dropped. The block must then hold its registered address and later resume at the correct skipped position. To bring this case about, the bench runs lengths just above a power of two, where nearly half the indices are dropped, and drives ready from a pseudo-random pattern and from an alternating pattern. Every accepted address is compared with a sequence the bench computes on its own. A second start with a different length is also raised in the middle of a run, and the bench confirms that the running sequence comes out unchanged.

// File: rtl/pbr_pkg.sv
package pbr_pkg;

   // width of a lane selector, never below one bit
   function automatic int unsigned sel_width(input int unsigned lanes);
      int unsigned w;
      w = 1;
      while ((32'd1 << w) < lanes) w = w + 1;
      return w;
   endfunction

endpackage

// File: rtl/pbr_len_decode.sv
module pbr_len_decode #(
   parameter int NMAX = 8,
   parameter int SW   = $clog2(NMAX + 1)
) (
   input  logic [NMAX:0]   len_i,
   output logic [SW-1:0]   shift_o,
   output logic [NMAX:0]   msize_o,
   output logic            legal_o
);
   logic [NMAX:0] len_m1;
   int            nbits;

   always_comb begin
      len_m1 = len_i - 1'b1;
      nbits  = 0;
      for (int i = 0; i <= NMAX; i++) begin
         if (len_m1[i]) nbits = i + 1;
      end
      if (nbits > NMAX) nbits = NMAX;
      shift_o = SW'(NMAX - nbits);
      msize_o = (NMAX+1)'(1) << nbits;
      legal_o = (len_i != '0) && (len_i <= ((NMAX+1)'(1) << NMAX));
   end
endmodule

// File: rtl/pbr_rev_lane.sv
module pbr_rev_lane #(
   parameter int NMAX = 8,
   parameter int SW   = $clog2(NMAX + 1)
) (
   input  logic [NMAX:0]   idx_i,
   input  logic [SW-1:0]   shift_i,
   input  logic [NMAX:0]   msize_i,
   input  logic [NMAX:0]   len_i,
   output logic [NMAX-1:0] rev_o,
   output logic            hit_o
);
   logic [NMAX-1:0] mirrored;

   for (genvar b = 0; b < NMAX; b++) begin : g_mirror
      assign mirrored[b] = idx_i[NMAX-1-b];
   end

   assign rev_o = mirrored >> shift_i;
   assign hit_o = (idx_i < msize_i) && ({1'b0, rev_o} < len_i);
endmodule

// File: rtl/pbr_first_hit.sv
module pbr_first_hit #(
   parameter int LANES = 2,
   parameter int IW    = 1
) (
   input  logic [LANES-1:0] hit_i,
   output logic             found_o,
   output logic [IW-1:0]    sel_o
);
   always_comb begin
      found_o = 1'b0;
      sel_o   = '0;
      for (int k = LANES - 1; k >= 0; k--) begin
         if (hit_i[k]) begin
            found_o = 1'b1;
            sel_o   = IW'(k);
         end
      end
   end
endmodule

// File: rtl/pbr_addr_gen.sv
module pbr_addr_gen #(
   parameter int NMAX  = 8,
   parameter int LANES = 2
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            start_i,
   input  logic [NMAX:0]   len_i,
   input  logic            ready_i,
   output logic            valid_o,
   output logic [NMAX-1:0] addr_o,
   output logic            done_o
);
   localparam int SW = $clog2(NMAX + 1);
   localparam int IW = pbr_pkg::sel_width(LANES);

   if (NMAX < 1 || NMAX > 24) begin : g_bad_nmax
      $error("pbr_addr_gen: NMAX must lie in 1..24");
   end
   if (LANES < 2 || LANES > (1 << NMAX)) begin : g_bad_lanes
      $error("pbr_addr_gen: LANES must lie in 2..2**NMAX");
   end

   logic            busy_q, valid_q, done_q;
   logic [NMAX:0]   len_q, msize_q, ctr_q, issued_q;
   logic [SW-1:0]   shift_q;
   logic [NMAX-1:0] addr_q;

   logic [SW-1:0]   dec_shift;
   logic [NMAX:0]   dec_msize;
   logic            dec_legal;

   pbr_len_decode #(.NMAX(NMAX), .SW(SW)) u_dec (
      .len_i   (len_i),
      .shift_o (dec_shift),
      .msize_o (dec_msize),
      .legal_o (dec_legal)
   );

   logic [LANES-1:0] hit;
   logic [NMAX-1:0]  rev_l [LANES];

   for (genvar k = 0; k < LANES; k++) begin : g_lane
      pbr_rev_lane #(.NMAX(NMAX), .SW(SW)) u_lane (
         .idx_i   (ctr_q + (NMAX+1)'(k)),
         .shift_i (shift_q),
         .msize_i (msize_q),
         .len_i   (len_q),
         .rev_o   (rev_l[k]),
         .hit_o   (hit[k])
      );
   end

   logic          found;
   logic [IW-1:0] sel;

   pbr_first_hit #(.LANES(LANES), .IW(IW)) u_pick (
      .hit_i   (hit),
      .found_o (found),
      .sel_o   (sel)
   );

   logic load, fire, last;
   assign fire = valid_q && ready_i;
   assign last = fire && (issued_q == len_q);
   assign load = busy_q && (issued_q != len_q) && (!valid_q || ready_i) && found;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         busy_q   <= 1'b0;
         valid_q  <= 1'b0;
         done_q   <= 1'b0;
         len_q    <= '0;
         msize_q  <= '0;
         shift_q  <= '0;
         ctr_q    <= '0;
         issued_q <= '0;
         addr_q   <= '0;
      end else begin
         done_q <= last;
         if (!busy_q) begin
            if (start_i && dec_legal) begin
               busy_q   <= 1'b1;
               len_q    <= len_i;
               msize_q  <= dec_msize;
               shift_q  <= dec_shift;
               ctr_q    <= '0;
               issued_q <= '0;
            end
         end else begin
            if (load) begin
               addr_q   <= rev_l[sel];
               valid_q  <= 1'b1;
               ctr_q    <= ctr_q + (NMAX+1)'(sel) + 1'b1;
               issued_q <= issued_q + 1'b1;
            end else if (fire) begin
               valid_q <= 1'b0;
            end
            if (last) busy_q <= 1'b0;
         end
      end
   end

   assign valid_o = valid_q;
   assign addr_o  = addr_q;
   assign done_o  = done_q;
endmodule

// File: rtl/pbr_addr_gen_chk.sv
module pbr_addr_gen_chk #(
   parameter int NMAX = 8
) (
   input logic            clk,
   input logic            rst_n,
   input logic            ready_i,
   input logic            valid_o,
   input logic [NMAX-1:0] addr_o,
   input logic            done_o,
   input logic            busy_q,
   input logic [NMAX:0]   len_q,
   input logic [NMAX:0]   issued_q
);
   AST_ADDR_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
      valid_o |-> ({1'b0, addr_o} < len_q)); // R4
   AST_STALL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (valid_o && !ready_i) |=> (valid_o && $stable(addr_o))); // R6
   AST_NO_GAP: assert property (@(posedge clk) disable iff (!rst_n)
      (valid_o && ready_i && (issued_q != len_q)) |=> valid_o); // R5
   AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
      done_o |=> !done_o); // R7
   AST_DONE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      done_o |-> !valid_o); // R7
   AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      !busy_q |-> !valid_o); // R8
endmodule

bind pbr_addr_gen pbr_addr_gen_chk #(.NMAX(NMAX)) u_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .ready_i  (ready_i),
   .valid_o  (valid_o),
   .addr_o   (addr_o),
   .done_o   (done_o),
   .busy_q   (busy_q),
   .len_q    (len_q),
   .issued_q (issued_q)
);

// File: tb/pbr_addr_gen_tb.sv
`timescale 1ns/1ps
module pbr_addr_gen_tb;
   localparam int NMAX = 8;
   localparam int MAXM = 1 << NMAX;

   logic            clk = 1'b0;
   logic            rst_n = 1'b0;
   logic            start_i = 1'b0;
   logic [NMAX:0]   len_i = '0;
   logic            ready_i = 1'b0;
   logic            valid_o;
   logic [NMAX-1:0] addr_o;
   logic            done_o;

   int checks = 0;
   int failures = 0;
   logic [15:0] lfsr = 16'hACE1;

   always #2.5 clk = ~clk;

   pbr_addr_gen #(.NMAX(NMAX), .LANES(2)) u_dut (
      .clk(clk), .rst_n(rst_n), .start_i(start_i), .len_i(len_i),
      .ready_i(ready_i), .valid_o(valid_o), .addr_o(addr_o), .done_o(done_o)
   );

   task automatic check(input bit ok, input string req, input int act, input int exp);
      checks++;
      if (!ok) begin
         failures++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   // mode 0: ready high, 1: pseudo-random, 2: alternating; poke: second start mid-run
   task automatic run_case(input int len, input int mode, input bit poke);
      int exp_a [MAXM];
      int n, cnt, got, cyc, gaps, mism, done_early;
      bit seen, stall_prev, r, stall_bad;
      int stall_addr;
      bit used [MAXM];
      bit dup;
      n = 0;
      while ((1 << n) < len) n++;
      cnt = 0;
      for (int i = 0; i < (1 << n); i++) begin
         int rv;
         rv = 0;
         for (int b = 0; b < n; b++) if (((i >> b) & 1) != 0) rv |= 1 << (n - 1 - b);
         if (rv < len) begin exp_a[cnt] = rv; cnt++; end
      end
      check(cnt == len, "R3 expected-count", cnt, len);
      for (int i = 0; i < MAXM; i++) used[i] = 1'b0;
      @(negedge clk);
      start_i = 1'b1; len_i = (NMAX+1)'(len);
      @(negedge clk);
      start_i = 1'b0; len_i = '0;
      got = 0; cyc = 0; gaps = 0; mism = 0; done_early = 0;
      seen = 0; stall_prev = 0; stall_bad = 0; stall_addr = 0; dup = 0;
      while (got < len && cyc < 4000) begin
         case (mode)
            0: r = 1'b1;
            1: begin lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]}; r = lfsr[0] | lfsr[3]; end
            default: r = cyc[0];
         endcase
         ready_i = r;
         if (stall_prev && !(valid_o && int'(addr_o) == stall_addr)) stall_bad = 1;
         if (done_o) done_early++;
         if (valid_o) seen = 1;
         else if (seen && mode == 0) gaps++;
         if (valid_o && ready_i) begin
            if (int'(addr_o) != exp_a[got]) begin
               if (mism == 0) check(0, "R2 address", int'(addr_o), exp_a[got]);
               mism++;
            end
            if (used[addr_o]) dup = 1;
            used[addr_o] = 1'b1;
            got++;
         end
         stall_prev = valid_o && !ready_i;
         stall_addr = int'(addr_o);
         if (poke && cyc == 3) begin start_i = 1'b1; len_i = (NMAX+1)'(5); end
         if (poke && cyc == 4) begin start_i = 1'b0; len_i = '0; end
         @(negedge clk);
         cyc++;
      end
      start_i = 1'b0;
      check(got == len, "R2 address count", got, len);
      check(mism == 0, poke ? "R8 sequence with ignored start" : "R2 sequence", mism, 0);
      check(!dup, "R4 distinct addresses", dup, 0);
      if (mode == 0) check(gaps == 0, "R5 no empty cycle", gaps, 0);
      else check(!stall_bad, "R6 hold under stall", stall_bad, 0);
      check(done_early == 0, "R7 no early done", done_early, 0);
      check(done_o == 1'b1 && valid_o == 1'b0, "R7 done after last", done_o, 1);
      ready_i = 1'b1;
      @(negedge clk);
      check(done_o == 1'b0 && valid_o == 1'b0, "R7 single pulse", done_o, 0);
   endtask

   task automatic illegal_start(input int len);
      int bad;
      bad = 0;
      @(negedge clk);
      start_i = 1'b1; len_i = (NMAX+1)'(len);
      ready_i = 1'b1;
      @(negedge clk);
      start_i = 1'b0; len_i = '0;
      for (int i = 0; i < 20; i++) begin
         if (valid_o || done_o) bad++;
         @(negedge clk);
      end
      check(bad == 0, "R8 illegal length ignored", bad, 0);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      check(valid_o == 1'b0 && done_o == 1'b0, "R1 in reset", valid_o, 0);
      rst_n = 1'b1;
      @(negedge clk);
      check(valid_o == 1'b0 && done_o == 1'b0, "R1 after reset", valid_o, 0);
      run_case(1, 0, 0);     // R3 single address
      run_case(2, 0, 0);
      run_case(3, 2, 0);
      run_case(5, 1, 0);
      run_case(100, 1, 0);
      run_case(128, 0, 0);   // R3 power of two
      run_case(129, 1, 0);
      run_case(129, 2, 0);
      run_case(256, 0, 0);
      run_case(200, 0, 1);   // R8 start during run
      illegal_start(0);
      illegal_start(300);
      run_case(4, 0, 0);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

   initial begin
      #(200000 * 5);
      failures++;
      checks++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end
endmodule